// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a target on a two-wire open-drain serial bus that presents a 4 KB byte-addressed memory at one fixed 7-bit bus address. It watches the clock and data lines through a synchroniser and detects bus start, repeated start and stop conditions. It answers only when the received address matches its own. Its single output is an enable that pulls the data line low. The enclosing pad logic turns that enable into an open-drain driver.

A write message carries two location bytes, high byte first, and then any number of data bytes. The data bytes go into a one-page staging buffer of 32 bytes. They reach the memory only when a stop condition closes the message. A programmable busy window follows each commit, and during it the target leaves its bus address unanswered. A read message streams bytes from the current location, and the location advances after every byte. A random read sets the location with a write message, then issues a repeated start with the read bit.

Top module: `serial_mem_target`

## Requirements
- R1: The target pulls SDA low during the ninth clock of an address byte only when the upper seven bits equal `DEV_ADDR` (default 7'h50; bit 0 is 0 for write, 1 for read). After a mismatch it leaves SDA released until the next start condition.
- R2: In a write message the first byte after the address selects location bits 11:8 from its four low bits, and its upper four bits are ignored. The second byte gives location bits 7:0. Both bytes are acknowledged.
- R3: Data bytes of a write are stored at consecutive locations inside one 32-byte page. The low five location bits wrap, so a byte past the page end lands at the start of the same page. Locations outside that page keep their contents.
- R4: Written bytes reach the memory only when a stop ends the message. A start condition that arrives before that stop discards the buffered bytes.
- R5: For `BUSY_CYCLES` clocks after a stop that commits data, the target does not acknowledge its own address. Once that window has passed it acknowledges again.
- R6: A write message with only the two location bytes moves the location pointer and starts no busy window. The pointer holds across separate messages.
- R7: After a matching read address, the target returns the byte at the current location, most significant bit first.
- R8: The location pointer advances by one after every byte read. It crosses page boundaries, and it wraps from 0xFFF to 0x000.
- R9: When the controller answers a read byte with NACK (SDA high in the ninth clock), the target releases SDA. It drives nothing more until the next start condition.
- R10: The target changes its SDA enable from released to driving only while SCL is low.
- R11: A start condition in the middle of a byte clears the bit count, so the next byte is framed from its first bit.
- R12: After reset SDA is released, and the first addressed message is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The case hardest to reach from the pins is a write whose buffered bytes are dropped. The controller must send data bytes and then issue a repeated start without a stop. The same combined message then re-addresses the location and reads it back. The old value must still be there, and no busy window may have started. The busy window is reached by sending a new start and address straight after the stop that commits a write, before the window can expire. Page wrap is driven by starting a six-byte write four bytes before a page end. The wrapped bytes and the untouched next page are then read back in one sequential read.

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE = 1 << PAGE_W;
  localparam int BUSY_LEN = (BUSY_CYCLES < PAGE) ? PAGE : BUSY_CYCLES;
  localparam int CNT_W = $clog2(BUSY_LEN + 1);
  localparam int HI_W = ADDR_W - 8;

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD} st_t;
  typedef enum logic [1:0] {PH_BITS, PH_SACK, PH_MACK} ph_t;

  logic [2:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_s, sda_p;
  logic start_det, stop_det, scl_rise, scl_fall;

  st_t st;
  ph_t ph;
  logic [3:0] bitc;
  logic [7:0] shreg, txsh, rd_q;
  logic mack, wr_pend;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0] pvalid;
  logic [CNT_W-1:0] busy_cnt;
  logic [PAGE_W:0] cidx;
  logic busy, buf_we, commit_we;

  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  assign scl_s = scl_q[1];
  assign scl_p = scl_q[2];
  assign sda_s = sda_q[1];
  assign sda_p = sda_q[2];
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;

  assign busy      = (busy_cnt != '0);
  assign buf_we    = scl_fall && ph == PH_BITS && bitc == 4'd8 && st == ST_WR;
  assign commit_we = busy && !cidx[PAGE_W] && pvalid[cidx[PAGE_W-1:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_BITS;
      bitc    <= '0;
      shreg   <= '0;
      txsh    <= '0;
      mack    <= 1'b0;
      wr_pend <= 1'b0;
      ptr     <= '0;
      pvalid  <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      st      <= ST_DEV;
      ph      <= PH_BITS;
      bitc    <= '0;
      sda_oe  <= 1'b0;
      wr_pend <= 1'b0;
    end else if (stop_det) begin
      st      <= ST_IDLE;
      ph      <= PH_BITS;
      bitc    <= '0;
      sda_oe  <= 1'b0;
      wr_pend <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (ph == PH_BITS) begin
          bitc  <= bitc + 4'd1;
          shreg <= {shreg[6:0], sda_s};
        end else if (ph == PH_MACK) begin
          mack <= ~sda_s;
        end
      end else if (scl_fall) begin
        case (ph)
          PH_BITS:
            if (bitc == 4'd8) begin
              if (st == ST_RD) begin
                sda_oe <= 1'b0;
                ph     <= PH_MACK;
                ptr    <= ptr + 1'b1;
              end else begin
                ph     <= PH_SACK;
                sda_oe <= 1'b1;
                case (st)
                  ST_DEV:
                    if (shreg[7:1] == DEV_ADDR && !busy) begin
                      st <= shreg[0] ? ST_RD : ST_AHI;
                      if (!shreg[0]) pvalid <= '0;
                    end else begin
                      st     <= ST_IDLE;
                      ph     <= PH_BITS;
                      sda_oe <= 1'b0;
                    end
                  ST_AHI: begin
                    ptr[ADDR_W-1:8] <= shreg[HI_W-1:0];
                    st <= ST_ALO;
                  end
                  ST_ALO: begin
                    ptr[7:0] <= shreg;
                    st <= ST_WR;
                  end
                  default: begin
                    pvalid[ptr[PAGE_W-1:0]] <= 1'b1;
                    ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                    wr_pend <= 1'b1;
                  end
                endcase
              end
            end else if (st == ST_RD && bitc != 4'd0) begin
              sda_oe <= ~txsh[6];
              txsh   <= {txsh[6:0], 1'b0};
            end
          PH_SACK: begin
            bitc <= '0;
            ph   <= PH_BITS;
            if (st == ST_RD) begin
              txsh   <= rd_q;
              sda_oe <= ~rd_q[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
          default:
            if (mack) begin
              bitc   <= '0;
              ph     <= PH_BITS;
              txsh   <= rd_q;
              sda_oe <= ~rd_q[7];
            end else begin
              st <= ST_IDLE;
              ph <= PH_BITS;
            end
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_cnt <= '0;
      cidx     <= '0;
    end else if (stop_det && wr_pend) begin
      busy_cnt <= CNT_W'(BUSY_LEN);
      cidx     <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
      if (!cidx[PAGE_W]) cidx <= cidx + 1'b1;
    end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[ptr[PAGE_W-1:0]] <= shreg;
    if (commit_we) mem[{ptr[ADDR_W-1:PAGE_W], cidx[PAGE_W-1:0]}] <= pbuf[cidx[PAGE_W-1:0]];
    rd_q <= mem[ptr];
  end

  AST_ADDR_NACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && st == ST_DEV |-> !sda_oe); // R5
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R10
  AST_PAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_WR && $past(st) == ST_WR |-> $stable(ptr[ADDR_W-1:PAGE_W])); // R3
  AST_STOP_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && wr_pend |=> busy); // R4
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_RD && $past(st) == ST_RD && !$stable(ptr) |-> ptr == ADDR_W'($past(ptr) + 1'b1)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE && $past(st) == ST_IDLE |-> !sda_oe); // R9
endmodule

// File: tb/serial_mem_target_tb.sv
module serial_mem_target_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int checks = 0;
  int fails = 0;
  int viol = 0;
  int quiet_hits = 0;
  logic watch = 1'b0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  localparam logic [7:0] DEVW = 8'hA0;
  localparam logic [7:0] DEVR = 8'hA1;
  localparam int BUSY = 600;

  localparam logic [19:0] VEC [8] = '{
    20'h001_3E, 20'h0FF_C7, 20'h100_01, 20'h2AB_80,
    20'h555_E1, 20'h7FE_5B, 20'h800_FF, 20'hABC_6D
  };

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  serial_mem_target #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (sda_oe && !oe_prev && scl_m) viol++;
    if (watch && sda_oe) quiet_hits++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (8) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hq(); scl_m = 1'b1; hq(); scl_m = 1'b0; hq();
    end
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); ack = ~sda_line; scl_m = 1'b0; hq();
  endtask

  task automatic rb(input logic last, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); scl_m = 1'b1; hq(); b[i] = sda_line; scl_m = 1'b0;
    end
    hq(); sda_m = last; hq(); scl_m = 1'b1; hq(); scl_m = 1'b0; hq(); sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo, output logic ok);
    logic a0, a1, a2;
    bstart(); wb(DEVW, a0); wb(hi, a1); wb(lo, a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic write1(input logic [11:0] addr, input logic [7:0] d, output logic ok);
    logic p, a;
    set_ptr({4'h0, addr[11:8]}, addr[7:0], p); wb(d, a); bstop();
    ok = p & a;
    repeat (BUSY + 100) @(negedge clk);
  endtask

  task automatic read_at(input logic [11:0] addr, output logic [7:0] d, output logic ok);
    logic p, a;
    set_ptr({4'h0, addr[11:8]}, addr[7:0], p); bstart(); wb(DEVR, a); rb(1'b1, d); bstop();
    ok = p & a;
  endtask

  initial begin
    logic ok, ack, ack2;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R12 reset releases SDA", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    bstart(); wb(DEVW, ack); bstop();
    chk(ack == 1'b1, "R12 first address acked", ack, 1);

    foreach (VEC[k]) begin
      write1(VEC[k][19:8], VEC[k][7:0], ok);
      read_at(VEC[k][19:8], d, ack);
      chk(ok & ack, "R2 write/read message acks", {ok, ack}, 2'b11);
      chk(d == VEC[k][7:0], "R7 random read returns byte", d, VEC[k][7:0]);
    end

    bstart(); wb(8'hA2, ack); wb(8'h00, ack2); bstop();
    chk(ack == 1'b0 && ack2 == 1'b0, "R1 foreign address unanswered", {ack, ack2}, 0);

    write1(12'h123, 8'h9E, ok);
    set_ptr(8'hF1, 8'h23, ok); bstart(); wb(DEVR, ack); rb(1'b1, d); bstop();
    chk(d == 8'h9E, "R2 high byte upper bits ignored", d, 8'h9E);

    write1(12'h140, 8'h77, ok);
    set_ptr(8'h01, 8'h3C, ok);
    for (int i = 0; i < 6; i++) wb(8'hC0 + 8'(i), ack);
    bstop();
    repeat (BUSY + 100) @(negedge clk);
    set_ptr(8'h01, 8'h3C, ok); bstart(); wb(DEVR, ack);
    for (int i = 0; i < 5; i++) begin
      rb(i == 4, d);
      if (i < 4) chk(d == 8'hC0 + 8'(i), "R3 page bytes stored in order", d, 8'hC0 + 8'(i));
      else chk(d == 8'h77, "R3 next page untouched, R8 read crosses page", d, 8'h77);
    end
    bstop();
    read_at(12'h120, d, ok);
    chk(d == 8'hC4, "R3 page wrap first byte", d, 8'hC4);
    read_at(12'h121, d, ok);
    chk(d == 8'hC5, "R3 page wrap second byte", d, 8'hC5);

    set_ptr(8'h01, 8'h00, ok); wb(8'h3A, ack); bstop();
    bstart(); wb(DEVW, ack); bstop();
    chk(ack == 1'b0, "R5 address ignored while busy", ack, 0);
    repeat (BUSY + 100) @(negedge clk);
    bstart(); wb(DEVW, ack); bstop();
    chk(ack == 1'b1, "R5 address acked after busy", ack, 1);
    read_at(12'h100, d, ok);
    chk(d == 8'h3A, "R4 stop commits data", d, 8'h3A);

    write1(12'h200, 8'hAA, ok);
    set_ptr(8'h02, 8'h00, ok); wb(8'h55, ack);
    set_ptr(8'h02, 8'h00, ok); bstart(); wb(DEVR, ack); rb(1'b1, d); bstop();
    chk(d == 8'hAA, "R4 repeated start discards buffered write", d, 8'hAA);
    bstart(); wb(DEVW, ack); bstop();
    chk(ack == 1'b1, "R4 discarded write starts no busy window", ack, 1);

    set_ptr(8'h05, 8'h55, ok); bstop();
    bstart(); wb(DEVR, ack); rb(1'b1, d); bstop();
    chk(ack == 1'b1 && d == 8'hE1, "R6 pointer-only write, no busy", {ack, d}, {1'b1, 8'hE1});

    write1(12'hFFF, 8'h3C, ok);
    write1(12'h000, 8'h4D, ok);
    set_ptr(8'h0F, 8'hFF, ok); bstart(); wb(DEVR, ack);
    rb(1'b0, d);
    chk(d == 8'h3C, "R8 top location", d, 8'h3C);
    rb(1'b1, d);
    chk(d == 8'h4D, "R8 pointer wraps to zero", d, 8'h4D);
    quiet_hits = 0; watch = 1'b1;
    for (int i = 0; i < 9; i++) begin
      hq(); scl_m = 1'b1; hq(); scl_m = 1'b0;
    end
    hq(); watch = 1'b0;
    bstop();
    chk(quiet_hits == 0, "R9 released after NACK", quiet_hits, 0);

    bstart();
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; hq(); scl_m = 1'b1; hq(); scl_m = 1'b0; hq();
    end
    bstart(); wb(DEVW, ack); bstop();
    chk(ack == 1'b1, "R11 mid-byte start reframes", ack, 1);

    chk(viol == 0, "R10 SDA driven only with SCL low", viol, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule